// File: doc/BRIEF.md
# Circular Double-Buffered Sample Capture

This block takes a stream of 16-bit samples. Each sample arrives with a one-cycle trigger strobe from an outside sample-rate timer. The block stores each sample in the next slot of an internal circular RAM of `DEPTH` entries. After the last slot it wraps back to slot 0, and it keeps capturing for as long as `enable_i` is high. The RAM is handled as two halves. When the lower half has just been filled, the block emits a half event. When the upper half has just been filled, it emits a full event. A block-processing consumer can therefore work on one half while the writer fills the other. At a trigger rate fs, an event appears every (DEPTH/2)/fs, which gives two events per lap.

A half becomes owned by the consumer when its event fires. The consumer reads the half through a synchronous read port and then gives it back with a done strobe for that half. If the writer starts a half that the consumer still owns, the block raises a sticky overrun flag. Both events also set sticky status bits, which are cleared by writing 1. An interrupt line is the OR of the status bits that are enabled.

Top module: `cap_dbuf`

## Requirements
- R1: The buffer holds `DEPTH` entries of 16 bits. A sample is stored at the current write index in any cycle where `enable_i` and `trig_i` are both high. `rd_data_o` shows the entry at `rd_addr_i` one cycle after the address is applied. If a read and a write hit the same address in the same cycle, the read returns the old contents.
- R2: Each enabled trigger moves `wr_idx_o` up by exactly one on the next cycle. Without a trigger the index holds.
- R3: A trigger that writes index `DEPTH-1` sets `wr_idx_o` to 0 on the next cycle, and capture continues from there.
- R4: `half_evt_o` is high for exactly one cycle, in the cycle after the write of index `DEPTH/2-1`.
- R5: `full_evt_o` is high for exactly one cycle, in the cycle after the write of index `DEPTH-1`.
- R6: `owned_lo_o` / `owned_hi_o` go high in the cycle after the matching event pulse. They stay high until `done_lo_i` / `done_hi_i` is sampled, and drop in the cycle after that.
- R7: `ovr_o` goes high in the cycle after an enabled write to index 0 while the lower half is owned and `done_lo_i` is low. It also goes high after an enabled write to index `DEPTH/2` while the upper half is owned and `done_hi_i` is low. Once set it stays high until cleared through `clr_i[2]`.
- R8: `half_sts_o` and `full_sts_o` go high in the cycle after the matching event pulse and stay high. Writing 1 to `clr_i[0]` clears the half bit, `clr_i[1]` clears the full bit and `clr_i[2]` clears the overrun bit. If a set and a clear land in the same cycle, the set wins.
- R9: `irq_o` is the OR of the half, full and overrun status bits, each masked by `irq_en_i[0]`, `irq_en_i[1]` and `irq_en_i[2]` respectively. It follows the inputs within the same cycle.
- R10: While `enable_i` is low, no sample is stored and no event fires. On the next cycle the write index is 0 and both ownership flags are clear. Status bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Capture enable; low stops capture and rewinds |
| trig_i | input | 1 | One-cycle sample strobe |
| sample_i | input | 16 | Sample value |
| done_lo_i | input | 1 | Consumer releases lower half |
| done_hi_i | input | 1 | Consumer releases upper half |
| clr_i | input | 3 | Write-1-to-clear: [0] half, [1] full, [2] overrun |
| irq_en_i | input | 3 | Interrupt enables, same bit order as clr_i |
| rd_addr_i | input | $clog2(DEPTH) | Read address |
| half_evt_o | output | 1 | Lower half filled pulse |
| full_evt_o | output | 1 | Upper half filled pulse |
| owned_lo_o | output | 1 | Lower half held by consumer |
| owned_hi_o | output | 1 | Upper half held by consumer |
| wr_idx_o | output | $clog2(DEPTH) | Next write index |
| half_sts_o | output | 1 | Sticky half status |
| full_sts_o | output | 1 | Sticky full status |
| ovr_o | output | 1 | Sticky overrun status |
| irq_o | output | 1 | Interrupt request |
| rd_data_o | output | 16 | Read data, one cycle latency |

## Verification
The assertions assume `trig_i` is a clean level sampled on each clock, with at most one sample per cycle. They also assume `DEPTH` is even and at least 4, so the two event pulses can never coincide. Done and clear strobes are taken as arbitrary, including cases where they collide with event or lap cycles.

The stimulus keeps `DEPTH` at a small even value. It drives triggers at random densities, up to one per cycle, which stays inside those assumptions. Done strobes are raised only some of the time while a half is owned. This forces laps into held halves, and so forces overruns. Clears, enables and read addresses vary freely.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int STS_W    = 3;
  localparam int STS_HALF = 0;
  localparam int STS_FULL = 1;
  localparam int STS_OVR  = 2;
  localparam int N_HALVES = 2;

  typedef struct packed {
    logic ovr;
    logic full;
    logic half;
  } cap_sts_t;
endpackage

// File: rtl/cap_wr_ptr.sv
module cap_wr_ptr #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          trig_i,
  output logic [AW-1:0] idx_o,
  output logic          we_o,
  output logic          evt_lo_o,
  output logic          evt_hi_o,
  output logic          lap_lo_o,
  output logic          lap_hi_o
);
  localparam int HALF = DEPTH / 2;
  localparam int LAST = DEPTH - 1;

  logic [AW-1:0] idx_q;
  logic          evt_lo_q, evt_hi_q;
  logic          fire;
  logic          at_half_end, at_last;

  assign fire        = en_i & trig_i;
  assign at_half_end = (idx_q == AW'(HALF - 1));
  assign at_last     = (idx_q == AW'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      evt_lo_q <= 1'b0;
      evt_hi_q <= 1'b0;
    end else begin
      evt_lo_q <= fire & at_half_end;
      evt_hi_q <= fire & at_last;
      if (!en_i)        idx_q <= '0;
      else if (trig_i)  idx_q <= at_last ? '0 : idx_q + AW'(1);
    end
  end

  assign idx_o    = idx_q;
  assign we_o     = fire;
  assign evt_lo_o = evt_lo_q;
  assign evt_hi_o = evt_hi_q;
  assign lap_lo_o = fire & (idx_q == '0);
  assign lap_hi_o = fire & (idx_q == AW'(HALF));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && trig_i && !at_last) |=> (idx_q == $past(idx_q) + AW'(1)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !trig_i) |=> (idx_q == $past(idx_q)));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && trig_i && at_last) |=> (idx_q == '0));
  a_r4_half_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_lo_q |-> ($past(idx_q) == AW'(HALF - 1)));
  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_lo_q && evt_hi_q));
  a_r10_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (idx_q == '0 && !evt_lo_q && !evt_hi_q));
endmodule

// File: rtl/cap_owner.sv
module cap_owner
  import cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic evt_lo_i,
  input  logic evt_hi_i,
  input  logic done_lo_i,
  input  logic done_hi_i,
  input  logic lap_lo_i,
  input  logic lap_hi_i,
  output logic owned_lo_o,
  output logic owned_hi_o,
  output logic ovr_hit_o
);
  logic [N_HALVES-1:0] evt, done, lap, owned_q, hit;

  assign evt  = {evt_hi_i, evt_lo_i};
  assign done = {done_hi_i, done_lo_i};
  assign lap  = {lap_hi_i, lap_lo_i};

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    owned_q[h] <= 1'b0;
      else if (!en_i) owned_q[h] <= 1'b0;
      else            owned_q[h] <= evt[h] | (owned_q[h] & ~done[h]);
    end
    // a done strobe in the lap cycle counts as a timely release
    assign hit[h] = lap[h] & owned_q[h] & ~done[h];

    a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done[h] && !evt[h]) |=> !owned_q[h]);
    a_r6_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && evt[h]) |=> owned_q[h]);
  end

  assign owned_lo_o = owned_q[0];
  assign owned_hi_o = owned_q[1];
  assign ovr_hit_o  = |hit;

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (owned_q == '0));
endmodule

// File: rtl/cap_status.sv
module cap_status
  import cap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  input  logic [STS_W-1:0] irq_en_i,
  output cap_sts_t         sts_o,
  output logic             irq_o
);
  logic [STS_W-1:0] sts_q;

  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[b] <= 1'b0;
      else         sts_q[b] <= set_i[b] | (sts_q[b] & ~clr_i[b]);
    end

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[b] && !clr_i[b]) |=> sts_q[b]);
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> sts_q[b]);
  end

  assign sts_o = cap_sts_t'(sts_q);
  assign irq_o = |(sts_q & irq_en_i);
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cap_dbuf.sv
module cap_dbuf
  import cap_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             trig_i,
  input  logic [DW-1:0]    sample_i,
  input  logic             done_lo_i,
  input  logic             done_hi_i,
  input  logic [STS_W-1:0] clr_i,
  input  logic [STS_W-1:0] irq_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             half_evt_o,
  output logic             full_evt_o,
  output logic             owned_lo_o,
  output logic             owned_hi_o,
  output logic [AW-1:0]    wr_idx_o,
  output logic             half_sts_o,
  output logic             full_sts_o,
  output logic             ovr_o,
  output logic             irq_o,
  output logic [DW-1:0]    rd_data_o
);
  localparam int HALF = DEPTH / 2;

  logic             we, evt_lo, evt_hi, lap_lo, lap_hi, ovr_hit;
  logic [AW-1:0]    idx;
  logic [STS_W-1:0] sts_set;
  cap_sts_t         sts;

  cap_wr_ptr #(.DEPTH(DEPTH), .AW(AW)) i_wr_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .trig_i   (trig_i),
    .idx_o    (idx),
    .we_o     (we),
    .evt_lo_o (evt_lo),
    .evt_hi_o (evt_hi),
    .lap_lo_o (lap_lo),
    .lap_hi_o (lap_hi)
  );

  cap_owner i_owner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (enable_i),
    .evt_lo_i   (evt_lo),
    .evt_hi_i   (evt_hi),
    .done_lo_i  (done_lo_i),
    .done_hi_i  (done_hi_i),
    .lap_lo_i   (lap_lo),
    .lap_hi_i   (lap_hi),
    .owned_lo_o (owned_lo_o),
    .owned_hi_o (owned_hi_o),
    .ovr_hit_o  (ovr_hit)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[STS_HALF] = evt_lo;
    sts_set[STS_FULL] = evt_hi;
    sts_set[STS_OVR]  = ovr_hit;
  end

  cap_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (sts_set),
    .clr_i    (clr_i),
    .irq_en_i (irq_en_i),
    .sts_o    (sts),
    .irq_o    (irq_o)
  );

  cap_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (idx),
    .wdata_i (sample_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign half_evt_o = evt_lo;
  assign full_evt_o = evt_hi;
  assign wr_idx_o   = idx;
  assign half_sts_o = sts.half;
  assign full_sts_o = sts.full;
  assign ovr_o      = sts.ovr;

  // overrun only ever starts on a lap into a half boundary
  a_r7_lap_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(enable_i && trig_i && (idx == '0 || idx == AW'(HALF))));
  a_r7_needs_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(owned_lo_o || owned_hi_o));
  a_r9_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (half_sts_o || full_sts_o || ovr_o));
  a_r5_full_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_evt_o |-> $past(enable_i && trig_i && idx == AW'(DEPTH - 1)));
endmodule

// File: tb/test_cap_dbuf.sv
module test_cap_dbuf;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int AW    = 4;
  localparam int DW    = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b0, trig_i = 1'b0, done_lo_i = 1'b0, done_hi_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic [2:0]    clr_i = '0, irq_en_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic          half_evt_o, full_evt_o, owned_lo_o, owned_hi_o;
  logic [AW-1:0] wr_idx_o;
  logic          half_sts_o, full_sts_o, ovr_o, irq_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  int      m_idx;
  bit      m_evt_lo, m_evt_hi, m_own_lo, m_own_hi, m_half, m_full, m_ovr;
  logic [DW-1:0] m_mem [DEPTH];
  bit      m_val [DEPTH];
  logic [DW-1:0] m_rd;
  bit      m_rdv;
  bit      m_wrapped, m_disabled;

  cap_dbuf #(.DEPTH(DEPTH), .DW(DW)) i_cap_dbuf (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_irq();
    return (m_half & irq_en_i[0]) | (m_full & irq_en_i[1]) | (m_ovr & irq_en_i[2]);
  endfunction

  task automatic compare();
    chk(m_disabled ? "R10" : (m_wrapped ? "R3" : "R2"), "wr_idx", int'(wr_idx_o), m_idx);
    chk("R4", "half_evt", int'(half_evt_o), int'(m_evt_lo));
    chk("R5", "full_evt", int'(full_evt_o), int'(m_evt_hi));
    chk(m_disabled ? "R10" : "R6", "owned_lo", int'(owned_lo_o), int'(m_own_lo));
    chk(m_disabled ? "R10" : "R6", "owned_hi", int'(owned_hi_o), int'(m_own_hi));
    chk("R7", "ovr", int'(ovr_o), int'(m_ovr));
    chk("R8", "half_sts", int'(half_sts_o), int'(m_half));
    chk("R8", "full_sts", int'(full_sts_o), int'(m_full));
    chk("R9", "irq", int'(irq_o), int'(exp_irq()));
    if (m_rdv) chk("R1", "rd_data", int'(rd_data_o), int'(m_rd));
  endtask

  // inputs already driven; advance model and design by one clock
  task automatic step();
    bit fire, hit, n_own_lo, n_own_hi;
    fire = enable_i & trig_i;
    hit  = fire && ((m_idx == 0 && m_own_lo && !done_lo_i) ||
                    (m_idx == HALF && m_own_hi && !done_hi_i));
    n_own_lo = enable_i ? (m_evt_lo | (m_own_lo & ~done_lo_i)) : 1'b0;
    n_own_hi = enable_i ? (m_evt_hi | (m_own_hi & ~done_hi_i)) : 1'b0;
    m_half = m_evt_lo | (m_half & ~clr_i[0]);
    m_full = m_evt_hi | (m_full & ~clr_i[1]);
    m_ovr  = hit | (m_ovr & ~clr_i[2]);
    m_own_lo = n_own_lo;
    m_own_hi = n_own_hi;
    m_evt_lo = fire && (m_idx == HALF - 1);
    m_evt_hi = fire && (m_idx == DEPTH - 1);
    m_rd  = m_mem[rd_addr_i];
    m_rdv = m_val[rd_addr_i];
    m_wrapped  = fire && (m_idx == DEPTH - 1);
    m_disabled = !enable_i;
    if (fire) begin
      m_mem[m_idx] = sample_i;
      m_val[m_idx] = 1'b1;
    end
    if (!enable_i)  m_idx = 0;
    else if (fire)  m_idx = (m_idx == DEPTH - 1) ? 0 : m_idx + 1;
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic drive(bit en, bit trig, bit dlo, bit dhi, logic [2:0] clr);
    enable_i  = en;
    trig_i    = trig;
    done_lo_i = dlo;
    done_hi_i = dhi;
    clr_i     = clr;
    sample_i  = DW'($urandom);
    rd_addr_i = AW'($urandom);
    step();
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    m_idx = 0; m_evt_lo = 0; m_evt_hi = 0; m_own_lo = 0; m_own_hi = 0;
    m_half = 0; m_full = 0; m_ovr = 0; m_rd = '0; m_rdv = 1; m_wrapped = 0; m_disabled = 0;
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_val[i] = 0; end
    repeat (3) @(negedge clk_i);
    // reset state
    compare();
    rst_ni = 1'b1;
    m_rdv = 0;
    irq_en_i = 3'b111;

    // R1 R2 R3 R4 R5 R6: two laps, trigger every cycle, prompt release
    for (int i = 0; i < 2 * DEPTH + 4; i++)
      drive(1, 1, m_own_lo, m_own_hi, 3'b000);
    chk("R7", "no overrun with prompt release", int'(ovr_o), 0);

    // R8: clear half and full status
    drive(1, 0, 0, 0, 3'b011);
    chk("R8", "half cleared", int'(half_sts_o), 0);

    // R7: consumer never releases, writer laps both halves
    for (int i = 0; i < 2 * DEPTH; i++)
      drive(1, 1, 0, 0, 3'b000);
    chk("R7", "overrun raised", int'(ovr_o), 1);
    // R9: mask overrun, keep others masked too
    irq_en_i = 3'b000;
    drive(1, 0, 0, 0, 3'b011);
    chk("R9", "irq masked", int'(irq_o), 0);
    irq_en_i = 3'b100;
    drive(1, 0, 1, 1, 3'b000);
    chk("R9", "irq from overrun", int'(irq_o), 1);
    drive(1, 0, 0, 0, 3'b100);
    chk("R7", "overrun cleared", int'(ovr_o), 0);

    // R10: disable mid-lap with triggers present
    for (int i = 0; i < 5; i++) drive(1, 1, 0, 0, 3'b000);
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 3'b000);
    chk("R10", "index rewound", int'(wr_idx_o), 0);
    // R1: read back every slot while idle
    for (int a = 0; a < DEPTH; a++) begin
      enable_i = 0; trig_i = 0; done_lo_i = 0; done_hi_i = 0; clr_i = '0;
      rd_addr_i = AW'(a);
      step();
    end

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 50 == 0) irq_en_i = 3'($urandom);
      drive(($urandom % 80) != 0,
            ($urandom % 3) != 0,
            m_own_lo && ($urandom % 4 == 0),
            m_own_hi && ($urandom % 4 == 0),
            {($urandom % 16 == 0), ($urandom % 8 == 0), ($urandom % 8 == 0)});
    end

    // R8: set and clear in same cycle, set wins
    for (int i = 0; i < DEPTH; i++) begin
      if (half_evt_o) begin
        drive(1, 0, 1, 1, 3'b001);
        chk("R8", "set beats clear", int'(half_sts_o), 1);
        break;
      end
      drive(1, 1, 1, 1, 3'b000);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule